// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer with Data Load

This block carries single-cycle event pulses from one clock domain into a second, unrelated clock domain. In the sending domain each event pulse flips a level register. That level is the only signal that crosses between the domains. In the receiving domain it passes through a chain of flip-flops. One more register after the chain lets the block compare the level with its previous value, and any change becomes exactly one receiving-cycle pulse.

The recovered pulse also acts as the load strobe for a multi-bit word that the sender presents next to its event. The word is never synchronized bit by bit. The receiving register takes it in one step, on the receiving edge where the strobe is high. The sender must keep the word unchanged from the moment it issues the pulse until that load has happened. Successive pulses must be spaced so that the receiving clock sees at least three rising edges between two level flips.

Top module: `xdom_pulse_link`

## Requirements
- R1: On each rising `a_clk` edge where `a_pulse` is 1, the source level register flips. On each edge where `a_pulse` is 0, it keeps its value. One input pulse therefore gives exactly one level transition.
- R2: Every source pulse gives exactly one `b_pulse`, provided the pulses are separated by at least three rising `b_clk` edges. No `b_pulse` appears without a source pulse.
- R3: `b_pulse` is high for exactly one `b_clk` cycle for each level transition.
- R4: On the rising `b_clk` edge where `b_pulse` is 1, `b_data` takes the value of `a_data`. The new value is visible from the next `b_clk` cycle.
- R5: On every rising `b_clk` edge where `b_pulse` is 0, `b_data` keeps its value, whatever `a_data` does.
- R6: `a_rst_n` and `b_rst_n` are active-low and asynchronous. They clear the source level, every synchronizer flop, the recovery flop and `b_data` to 0. No `b_pulse` appears after reset is released.
- R7: Pulses issued back to back at the minimum legal spacing each give their own `b_pulse`, and none is lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Source domain clock |
| a_rst_n | input | 1 | Source domain asynchronous reset, active low |
| a_pulse | input | 1 | Single-cycle event pulse, source domain |
| a_data | input | DATA_W | Word that goes with the event; the sender holds it until the load |
| b_clk | input | 1 | Destination domain clock |
| b_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| b_pulse | output | 1 | Recovered single-cycle pulse, destination domain |
| b_data | output | DATA_W | Word register, loaded when `b_pulse` is high |

## Verification
The two clocks run at 11.3 ns and 8 ns, so their edges slide past each other and the synchronizer latency varies from event to event.

Widely spaced events with distinct words, including all-ones, a single high bit and all-zeros, show whether each strobe loads the word belonging to its own event. A burst at the tightest legal spacing that repeats one word separates a lost or merged pulse from a correct one, because it can only be caught by counting pulses. A change of the word with no event is used to check that the register ignores the bus. A reset taken while the source level sits at 1 is used to check that no pulse appears when reset is released.

// File: rtl/xdom_pkg.sv
`timescale 1ns/1ps
package xdom_pkg;

  // Next value of the source level: one flip per event pulse.
  function automatic logic flip_level(input logic lvl, input logic pls);
    return lvl ^ pls;
  endfunction

  // A change between two successive samples of the crossed level.
  function automatic logic level_changed(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

endpackage

// File: rtl/xdom_src_toggle.sv
`timescale 1ns/1ps
module xdom_src_toggle
  import xdom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic level_out
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= flip_level(lvl_q, pulse_in);
  end

  assign level_out = lvl_q;

endmodule

// File: rtl/xdom_sync_chain.sv
`timescale 1ns/1ps
module xdom_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= 1'b0;
        else        stg_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_out = stg_q[STAGES-1];

endmodule

// File: rtl/xdom_edge_recover.sv
`timescale 1ns/1ps
module xdom_edge_recover
  import xdom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_prev,
  output logic pulse_out
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign level_prev = prev_q;
  assign pulse_out  = level_changed(level_in, prev_q);

endmodule

// File: rtl/xdom_dst_capture.sv
`timescale 1ns/1ps
module xdom_dst_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_out
);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= d_in;
  end

  assign q_out = word_q;

endmodule

// File: rtl/xdom_pulse_link.sv
`timescale 1ns/1ps
module xdom_pulse_link #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_pulse,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_clk,
  input  logic              b_rst_n,
  output logic              b_pulse,
  output logic [DATA_W-1:0] b_data
);

  // Named internal events, brought out for the checker.
  logic src_level;   // source-domain toggled level
  logic sync_last;   // final synchronizer stage, destination domain
  logic sync_hold;   // one more destination flop after the chain
  logic load_strobe; // recovered pulse

  xdom_src_toggle u_toggle (
    .clk       (a_clk),
    .rst_n     (a_rst_n),
    .pulse_in  (a_pulse),
    .level_out (src_level)
  );

  xdom_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (b_clk),
    .rst_n (b_rst_n),
    .d_in  (src_level),
    .q_out (sync_last)
  );

  xdom_edge_recover u_recover (
    .clk        (b_clk),
    .rst_n      (b_rst_n),
    .level_in   (sync_last),
    .level_prev (sync_hold),
    .pulse_out  (load_strobe)
  );

  xdom_dst_capture #(.DATA_W(DATA_W)) u_capture (
    .clk   (b_clk),
    .rst_n (b_rst_n),
    .load  (load_strobe),
    .d_in  (a_data),
    .q_out (b_data)
  );

  assign b_pulse = load_strobe;

endmodule

// File: rtl/xdom_pulse_link_chk.sv
`timescale 1ns/1ps
module xdom_pulse_link_chk #(
  parameter int DATA_W = 16
) (
  input logic              a_clk,
  input logic              a_rst_n,
  input logic              a_pulse,
  input logic [DATA_W-1:0] a_data,
  input logic              b_clk,
  input logic              b_rst_n,
  input logic              b_pulse,
  input logic [DATA_W-1:0] b_data,
  input logic              src_level
);

  AST_SRC_FLIP: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_pulse |=> (src_level != $past(src_level))); // R1

  AST_SRC_HOLD: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !a_pulse |=> $stable(src_level)); // R1

  AST_PULSE_WIDTH: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_pulse |=> !b_pulse); // R3

  AST_LOAD_VALUE: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_pulse |=> (b_data == $past(a_data))); // R4

  AST_DATA_HOLD: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !b_pulse |=> $stable(b_data)); // R5

endmodule

bind xdom_pulse_link xdom_pulse_link_chk #(.DATA_W(DATA_W)) u_chk (
  .a_clk     (a_clk),
  .a_rst_n   (a_rst_n),
  .a_pulse   (a_pulse),
  .a_data    (a_data),
  .b_clk     (b_clk),
  .b_rst_n   (b_rst_n),
  .b_pulse   (b_pulse),
  .b_data    (b_data),
  .src_level (src_level)
);

// File: tb/sim_xdom_pulse_link.sv
`timescale 1ns/1ps
module sim_xdom_pulse_link;

  localparam int W = 16;

  logic         a_clk = 1'b0;
  logic         b_clk = 1'b0;
  logic         a_rst_n = 1'b0;
  logic         b_rst_n = 1'b0;
  logic         a_pulse = 1'b0;
  logic [W-1:0] a_data = '0;
  logic         b_pulse;
  logic [W-1:0] b_data;

  always #5.65 a_clk = ~a_clk;  // source clock, unrelated period
  always #4    b_clk = ~b_clk;  // 125 MHz destination clock

  xdom_pulse_link #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_pulse(a_pulse), .a_data(a_data),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_pulse(b_pulse), .b_data(b_data)
  );

  int total = 0;
  int bad   = 0;
  int sent  = 0;
  int seen  = 0;
  bit ended = 0;
  logic [W-1:0] expq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: one source pulse with its word, expected word queued.
  task automatic send(input logic [W-1:0] v, input int gap_b);
    @(negedge a_clk);
    a_data  = v;
    a_pulse = 1'b1;
    expq.push_back(v);
    sent++;
    @(negedge a_clk);
    a_pulse = 1'b0;
    repeat (gap_b) @(posedge b_clk);
  endtask

  // Monitor: every b_pulse pops one expected word.
  initial begin
    forever begin
      @(negedge b_clk);
      if (b_pulse) begin
        seen++;
        if (expq.size() == 0) begin
          check(1'b0, "R2", "pulse with no source event", 32'd1, 32'd0);
        end else begin
          logic [W-1:0] exp_v;
          exp_v = expq.pop_front();
          @(negedge b_clk);
          check(!b_pulse, "R3", "pulse width one cycle", {31'd0, b_pulse}, 32'd0);
          check(b_data == exp_v, "R4", "loaded word", {16'd0, b_data}, {16'd0, exp_v});
        end
      end
    end
  end

  // Watchdog
  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    // R6: state while in reset and just after release
    repeat (3) @(posedge b_clk);
    @(negedge b_clk);
    check(b_pulse == 1'b0, "R6", "pulse in reset", {31'd0, b_pulse}, 32'd0);
    check(b_data == '0, "R6", "word in reset", {16'd0, b_data}, 32'd0);
    a_rst_n = 1'b1;
    b_rst_n = 1'b1;
    repeat (12) @(negedge b_clk);
    check(seen == 0, "R6", "pulses after first release", seen, 32'd0);
    check(b_data == '0, "R6", "word after release", {16'd0, b_data}, 32'd0);

    // R2/R4: widely spaced events with distinct words
    send(16'hA5A5, 12);
    send(16'h0001, 12);
    send(16'hFFFF, 12);
    send(16'h8000, 12);
    send(16'h0000, 12);
    send(16'h5A3C, 12);
    check(seen == sent, "R2", "pulse count after spaced events", seen, sent);

    // R7: tight burst at minimum spacing, word held constant
    @(negedge a_clk);
    a_data = 16'h3C3C;
    repeat (12) @(posedge b_clk);
    for (int k = 0; k < 8; k++) send(16'h3C3C, 4);
    repeat (12) @(posedge b_clk);
    check(seen == sent, "R7", "pulse count after tight burst", seen, sent);

    // R5: word changes with no event, register must ignore it
    held = b_data;
    @(negedge a_clk);
    a_data = 16'hDEAD;
    repeat (15) @(posedge b_clk);
    @(negedge b_clk);
    check(b_data == held, "R5", "word without strobe", {16'd0, b_data}, {16'd0, held});
    check(seen == sent, "R5", "no pulse without event", seen, sent);

    // R6: reset while source level is 1 (odd number of events)
    send(16'h1357, 12);
    check(b_data == 16'h1357, "R4", "word before reset", {16'd0, b_data}, 32'h1357);
    @(negedge b_clk);
    a_rst_n = 1'b0;
    b_rst_n = 1'b0;
    #1;
    check(b_data == '0, "R6", "asynchronous clear", {16'd0, b_data}, 32'd0);
    repeat (4) @(posedge b_clk);
    @(negedge a_clk);
    a_rst_n = 1'b1;
    b_rst_n = 1'b1;
    repeat (20) @(negedge b_clk);
    check(seen == sent, "R6", "no pulse after reset release", seen, sent);
    check(b_data == '0, "R6", "word stays cleared", {16'd0, b_data}, 32'd0);

    // R1/R2: events resume normally after reset
    send(16'h2468, 12);
    send(16'h7E7E, 12);
    check(seen == sent, "R1", "one pulse per event after reset", seen, sent);
    check(expq.size() == 0, "R2", "expected queue drained", expq.size(), 32'd0);
    finish_run();
  end

endmodule